// File: doc/BRIEF.md
# Serial SAR Converter Link Emulator

This block stands in for the digital side of a chip-select-framed serial successive-approximation converter. A host drives an active-low select line and a serial clock; the block answers on a data line with an output-enable for tri-state control, so a controller can be exercised against a realistic converter without any analog parts. The value to be "converted" arrives on a parallel port and is captured at the moment select falls.

Each frame has sixteen output slots: two zero slots, the result with its most significant bit first, then zero fill. The block follows the conversion and acquisition phases from the host's clock edges. Where the host releases select decides what happens: a release before conversion completes throws away the result, a release inside a fixed early window puts the emulated device to sleep, and a sleeping device wakes only after a dummy frame that runs long enough. Wake-up then takes a programmable number of system clocks, and a ready output shows when frames carry real data again. The host lines are asynchronous and are brought into the system clock domain by a synchroniser chain.

Top module: `sar_link_emu`

## Requirements
- R1: After reset the data enable `sdo_oe` is low and `ready` is high; the first frame carries valid data.
- R2: A falling edge on `csn_in` captures `sample_in`, raises `sdo_oe` and presents slot 0 (a zero); changes on `sample_in` after that edge have no effect on the frame.
- R3: After the k-th falling edge of `sclk_in` (k from 1 to 15) the data line shows slot k: slots 0 and 1 are zero, slots 2 to RES_BITS+1 hold the captured sample with bit RES_BITS-1 in slot 2, and all later slots are zero.
- R4: The 16th falling edge of `sclk_in` lowers `sdo_oe`, and further falling edges in the same frame leave it low.
- R5: A rising edge on `csn_in` lowers `sdo_oe` whatever slot the frame has reached.
- R6: Raising `csn_in` before conversion has completed, and outside the sleep window of R8, aborts the conversion: every data slot of the next frame is zero, and the frame after that is valid again.
- R7: Conversion completes at the first rising edge of `sclk_in` that follows falling edge RES_BITS+1; a frame released at any point after that makes the next frame valid, even when it is shorter than sixteen slots.
- R8: Raising `csn_in` when 2 to 9 falling edges (inclusive) have been seen in the frame puts the block to sleep: `ready` goes low and frames carry zeros in every data slot.
- R9: While asleep, only a frame held low through its 10th falling edge starts wake-up; shorter frames leave the block asleep however long it waits.
- R10: `ready` rises PWRUP_CYCLES system clocks after the wake-up trigger; frames started before that carry zero data, and frames started after it carry the sample.
- R11: With RES_BITS set to 8 the result occupies slots 2 to 9 and conversion completes at the first rising edge after the 9th falling edge, so a frame released after 10 edges is not an abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Host serial clock, asynchronous, idles high |
| csn_in | input | 1 | Host chip select, active low, asynchronous |
| sample_in | input | RES_BITS | Value returned as the conversion result |
| sdo | output | 1 | Serial data toward the host |
| sdo_oe | output | 1 | High while the data line is driven; low means high impedance |
| ready | output | 1 | High when the emulated device is fully powered |

## Verification
The hardest state to reach from the ports is the boundary between abort and completion, which differs with the result width: a frame released after exactly ten clock edges is an abort for ten bits but a good conversion for eight. The bench therefore drives one stimulus stream into a ten-bit and an eight-bit instance side by side and predicts validity separately for each. Sleep and wake need long, ordered frame sequences (enter the window, send too-short dummy frames, idle past the wake delay, then a long dummy frame), which directed steps set up before a seeded random run of frame lengths from zero to eighteen edges revisits them.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

    // A frame always has sixteen output slots; five bits count them.
    localparam int FRAME_SLOTS = 16;
    localparam int LEAD_ZEROS  = 2;

    typedef logic [4:0] slot_cnt_t;

    localparam slot_cnt_t SLOT_LAST   = 5'd15;
    localparam slot_cnt_t SLOT_DONE   = 5'd16;
    localparam slot_cnt_t SLEEP_FIRST = 5'd2;
    localparam slot_cnt_t SLEEP_LAST  = 5'd9;
    localparam slot_cnt_t WAKE_PRIOR  = 5'd9;   // edge count just before the wake edge

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_DOWN = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_state_t;

    // Edge events from the host lines, one system clock wide.
    typedef struct packed {
        logic start;   // select fell
        logic stop;    // select rose
        logic fall;    // serial clock fell
        logic rise;    // serial clock rose
    } link_evt_t;

    // Frame outcome events for the power controller.
    typedef struct packed {
        logic end_any;   // frame closed by select rising
        logic end_ok;    // frame closed after conversion completed
        logic sleep_req; // frame closed inside the sleep window
        logic wake_hit;  // frame reached its wake edge
    } frame_evt_t;

    function automatic logic in_sleep_window(slot_cnt_t n);
        return (n >= SLEEP_FIRST) && (n <= SLEEP_LAST);
    endfunction

endpackage

// File: rtl/sar_link_sync.sv
module sar_link_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    // Each line gets its own chain; idle level of every host line is high.
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES:0] chain;

        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-1:0], async_in[g]};
        end

        assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
        assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/sar_link_frame.sv
module sar_link_frame
    import sar_link_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  link_evt_t           ev,
    input  logic [RES_BITS-1:0] sample,
    input  logic                frame_valid,
    output logic                sdo,
    output logic                sdo_oe,
    output frame_evt_t          fe
);
    localparam int        TRAIL     = FRAME_SLOTS - LEAD_ZEROS - RES_BITS;
    localparam slot_cnt_t CONV_EDGE = slot_cnt_t'(RES_BITS + 1);

    logic                   in_frame;
    logic                   conv_done;
    slot_cnt_t              cnt;
    logic [FRAME_SLOTS-1:0] word;
    logic [RES_BITS-1:0]    gated;

    always_comb begin
        gated = frame_valid ? sample : '0;
    end

    always_comb begin
        fe.end_any   = ev.stop && in_frame;
        fe.end_ok    = ev.stop && in_frame && conv_done;
        fe.sleep_req = ev.stop && in_frame && in_sleep_window(cnt);
        fe.wake_hit  = ev.fall && in_frame && !ev.stop && (cnt == WAKE_PRIOR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame  <= 1'b0;
            conv_done <= 1'b0;
            cnt       <= '0;
            word      <= '0;
            sdo       <= 1'b0;
            sdo_oe    <= 1'b0;
        end else if (ev.start) begin
            in_frame  <= 1'b1;
            conv_done <= 1'b0;
            cnt       <= '0;
            word      <= {{LEAD_ZEROS{1'b0}}, gated, {TRAIL{1'b0}}};
            sdo       <= 1'b0;
            sdo_oe    <= 1'b1;
        end else if (ev.stop) begin
            in_frame <= 1'b0;
            sdo_oe   <= 1'b0;
        end else if (in_frame) begin
            if (ev.fall && (cnt < SLOT_DONE)) begin
                cnt  <= cnt + 5'd1;
                word <= word << 1;
                sdo  <= word[FRAME_SLOTS-2];
                if (cnt == SLOT_LAST) sdo_oe <= 1'b0;
            end
            if (ev.rise && (cnt >= CONV_EDGE)) conv_done <= 1'b1;
        end
    end

    // R2: select falling drives a leading zero
    p_start_drive_r2: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (sdo_oe && !sdo))
        else $error("start of frame did not drive a zero");

    // R3: slots before the last keep the line driven
    p_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (in_frame && ev.fall && !ev.stop && (cnt < SLOT_LAST)) |=> sdo_oe)
        else $error("line released mid frame");

    // R4: sixteenth falling edge releases the line
    p_last_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (in_frame && ev.fall && !ev.stop && (cnt == SLOT_LAST)) |=> !sdo_oe)
        else $error("line still driven after the last slot");

    // R4: slot counter never runs past the frame
    p_slot_sat_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= SLOT_DONE)
        else $error("slot counter overran");

    // R5: select rising always releases the line
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sdo_oe)
        else $error("line driven after select rose");
endmodule

// File: rtl/sar_link_power.sv
module sar_link_power
    import sar_link_pkg::*;
#(
    parameter int PWRUP_CYCLES = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t fe,
    output logic       ready,
    output logic       frame_valid
);
    localparam int PW_W = $clog2(PWRUP_CYCLES + 1);

    pwr_state_t      state;
    logic            last_ok;
    logic [PW_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PWR_ON;
            last_ok  <= 1'b1;
            wait_cnt <= '0;
        end else begin
            unique case (state)
                PWR_ON: begin
                    if (fe.sleep_req)    state   <= PWR_DOWN;
                    else if (fe.end_any) last_ok <= fe.end_ok;
                end
                PWR_DOWN: begin
                    if (fe.wake_hit) begin
                        state    <= PWR_WAKE;
                        wait_cnt <= PW_W'(PWRUP_CYCLES - 1);
                    end
                end
                PWR_WAKE: begin
                    if (fe.sleep_req) begin
                        state <= PWR_DOWN;
                    end else if (wait_cnt == '0) begin
                        state   <= PWR_ON;
                        last_ok <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: state <= PWR_ON;
            endcase
        end
    end

    assign ready       = (state == PWR_ON);
    assign frame_valid = ready && last_ok;

    // R8: a release inside the sleep window always sleeps
    p_sleep_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (fe.sleep_req && (state != PWR_DOWN)) |=> (state == PWR_DOWN))
        else $error("sleep window release did not sleep");

    // R9: sleep is left only through the wake edge
    p_stay_down_r9: assert property (@(posedge clk) disable iff (rst)
        ((state == PWR_DOWN) && !fe.wake_hit) |=> (state == PWR_DOWN))
        else $error("left sleep without a wake frame");

    // R10: wake delay is not cut short
    p_wake_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ((state == PWR_WAKE) && (wait_cnt != '0) && !fe.sleep_req) |=> (state == PWR_WAKE))
        else $error("wake delay ended early");

    // R10: ready only comes back through the wake state
    p_ready_path_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(state) == PWR_WAKE))
        else $error("ready rose without wake-up");

    // R6: an aborted conversion invalidates the next frame
    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        ((state == PWR_ON) && fe.end_any && !fe.sleep_req && !fe.end_ok) |=> !frame_valid)
        else $error("aborted frame left data marked valid");
endmodule

// File: rtl/sar_link_emu.sv
module sar_link_emu
    import sar_link_pkg::*;
#(
    parameter int RES_BITS     = 10,
    parameter int PWRUP_CYCLES = 160,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_in,
    input  logic                csn_in,
    input  logic [RES_BITS-1:0] sample_in,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                ready
);
    localparam int LINES   = 2;
    localparam int IDX_SCK = 0;
    localparam int IDX_CS  = 1;

    logic [LINES-1:0] line_rise;
    logic [LINES-1:0] line_fall;
    link_evt_t        ev;
    frame_evt_t       fe;
    logic             frame_valid;

    sar_link_sync #(
        .N      (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({csn_in, sclk_in}),
        .rise     (line_rise),
        .fall     (line_fall)
    );

    always_comb begin
        ev.start = line_fall[IDX_CS];
        ev.stop  = line_rise[IDX_CS];
        ev.fall  = line_fall[IDX_SCK];
        ev.rise  = line_rise[IDX_SCK];
    end

    sar_link_frame #(
        .RES_BITS (RES_BITS)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .sample      (sample_in),
        .frame_valid (frame_valid),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .fe          (fe)
    );

    sar_link_power #(
        .PWRUP_CYCLES (PWRUP_CYCLES)
    ) u_power (
        .clk         (clk),
        .rst         (rst),
        .fe          (fe),
        .ready       (ready),
        .frame_valid (frame_valid)
    );

    // R1: out of reset the line is released and the device is powered
    p_reset_state_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!sdo_oe && ready))
        else $error("bad state after reset");
endmodule

// File: tb/sar_link_emu_test.sv
`timescale 1ns/1ps
module sar_link_emu_test;
    localparam int PWR  = 400;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b1;
    logic       csn = 1'b1;
    logic [9:0] samp_a = '0;
    logic [7:0] samp_b = '0;
    logic       sdo_a, oe_a, rdy_a, sdo_b, oe_b, rdy_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // bench model, index 0 = ten-bit, 1 = eight-bit
    int         st [2];     // 0 on, 1 asleep, 2 waking
    bit         lok [2];
    bit         fval [2];
    logic [9:0] fdat [2];
    int         wid [2];

    always #2.5 clk = ~clk;

    sar_link_emu #(.RES_BITS(10), .PWRUP_CYCLES(PWR)) uut (
        .clk(clk), .rst(rst), .sclk_in(sclk), .csn_in(csn), .sample_in(samp_a),
        .sdo(sdo_a), .sdo_oe(oe_a), .ready(rdy_a));

    sar_link_emu #(.RES_BITS(8), .PWRUP_CYCLES(PWR)) uut_b (
        .clk(clk), .rst(rst), .sclk_in(sclk), .csn_in(csn), .sample_in(samp_b),
        .sdo(sdo_b), .sdo_oe(oe_b), .ready(rdy_b));

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_bit(logic [9:0] d, int w, int k, bit v);
        if (!v) return 1'b0;
        if (k >= 2 && k < 2 + w) return d[w - 1 - (k - 2)];
        return 1'b0;
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_slot(int k, string tag);
        for (int i = 0; i < 2; i++) begin
            string t;
            logic  oe_v, sd_v;
            t    = (i == 1) ? {tag, "/R11"} : tag;
            oe_v = (i == 1) ? oe_b : oe_a;
            sd_v = (i == 1) ? sdo_b : sdo_a;
            if (k >= 16) begin
                chk(t, $sformatf("inst%0d oe slot %0d", i, k), oe_v, 1'b0);
            end else begin
                chk(t, $sformatf("inst%0d oe slot %0d", i, k), oe_v, 1'b1);
                chk(t, $sformatf("inst%0d data slot %0d", i, k), sd_v,
                    exp_bit(fdat[i], wid[i], k, fval[i]));
            end
        end
    endtask

    task automatic check_ready(string tag);
        chk(tag, "inst0 ready", rdy_a, (st[0] == 0));
        chk({tag, "/R11"}, "inst1 ready", rdy_b, (st[1] == 0));
    endtask

    // One frame of nf serial clock falling edges, each followed by a rise.
    task automatic run_frame(int nf, bit wiggle, string dtag);
        samp_a = 10'($urandom);
        samp_b = 8'($urandom);
        fdat[0] = samp_a;
        fdat[1] = {2'b00, samp_b};
        for (int i = 0; i < 2; i++) fval[i] = (st[i] == 0) && lok[i];
        csn = 1'b0;
        tick(HALF);
        check_slot(0, "R2");
        if (wiggle) begin
            samp_a = ~samp_a;   // R2: must not reach the frame
            samp_b = ~samp_b;
        end
        for (int k = 1; k <= nf; k++) begin
            sclk = 1'b0;
            tick(HALF);
            check_slot(k, (k >= 16) ? "R4" : dtag);
            sclk = 1'b1;
            tick(HALF);
        end
        csn = 1'b1;
        tick(HALF);
        chk("R5", "inst0 oe after release", oe_a, 1'b0);
        chk("R5", "inst1 oe after release", oe_b, 1'b0);
        for (int i = 0; i < 2; i++) begin
            bit done;
            done = (nf >= wid[i] + 1);
            if (st[i] != 1 && nf >= 2 && nf <= 9) st[i] = 1;
            else if (st[i] == 0) lok[i] = done;
            else if (st[i] == 1 && nf >= 10) st[i] = 2;
        end
        check_ready((st[0] == 1) ? "R8" : (st[0] == 2) ? "R9" : "R6");
        tick(HALF);
    endtask

    task automatic settle_power();
        if (st[0] == 2 || st[1] == 2) begin
            check_ready("R10");
            tick(PWR + 20);
            for (int i = 0; i < 2; i++) if (st[i] == 2) begin st[i] = 0; lok[i] = 1'b1; end
            check_ready("R10");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wid[0] = 10; wid[1] = 8;
        for (int i = 0; i < 2; i++) begin st[i] = 0; lok[i] = 1'b1; end

        tick(6);
        rst = 1'b0;
        tick(4);
        chk("R1", "inst0 oe at reset", oe_a, 1'b0);
        chk("R1", "inst1 oe at reset", oe_b, 1'b0);
        check_ready("R1");

        // full frames, extra edges past the end
        run_frame(18, 1'b1, "R3");
        run_frame(16, 1'b0, "R3");

        // release after ten edges: abort for ten bits, complete for eight
        run_frame(10, 1'b0, "R3");
        run_frame(16, 1'b0, "R6");
        run_frame(16, 1'b0, "R6");

        // shortest completing frame for ten bits
        run_frame(11, 1'b0, "R3");
        run_frame(16, 1'b0, "R7");

        // very early releases abort without sleeping
        run_frame(0, 1'b0, "R3");
        run_frame(16, 1'b0, "R6");
        run_frame(1, 1'b0, "R3");
        run_frame(16, 1'b0, "R6");
        run_frame(16, 1'b0, "R7");

        // sleep at the window start, short dummy frame, long idle
        run_frame(2, 1'b0, "R3");
        run_frame(5, 1'b0, "R8");
        tick(PWR + 40);
        check_ready("R9");
        run_frame(10, 1'b0, "R9");
        run_frame(16, 1'b0, "R10");
        settle_power();
        run_frame(16, 1'b0, "R10");

        // sleep at the window end, full dummy frame
        run_frame(9, 1'b0, "R3");
        run_frame(16, 1'b0, "R9");
        settle_power();
        run_frame(16, 1'b0, "R10");

        // seeded random frame lengths
        for (int r = 0; r < 40; r++) begin
            run_frame($urandom_range(0, 18), r[0], "R3");
            settle_power();
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule